// File: doc/BRIEF.md
# Pulse-Per-Second Capture and Conversion Trigger

This block takes a once-per-second timing pulse that has no fixed phase relation to the local 10 MHz clock. It turns the pulse into a gate window and a delayed converter start. The raw pulse also drives the data input of an external three-state driver that feeds an RC network. This block controls only that driver's enable. The capacitor therefore charges from the moment the pulse rises until the resynchronized copy of the pulse turns the enable off. The charge held on the capacitor is a measure of the sub-cycle phase of the pulse.

A capture flop set by the pulse edge holds the event, so even a very narrow pulse is seen. The captured level then enters a shift register. Its first stages are the synchronizer, and their latency sets the window. Its later stages count out a settling delay before a one-cycle conversion start. The sample/hold control stays in sample mode during the window and the settling delay. It switches to hold when the conversion starts and returns to sample after a fixed conversion time.

The block then re-arms once the pulse has gone low and the register has drained. Pulses that arrive while it is busy are ignored and counted. A sticky flag marks each new conversion until it is acknowledged.

Top module: `pps_conv_trigger`

## Requirements
- R1: While `rst_n` is low, at the clock edge, every stage is cleared, `gate_oe_o` is 0 (driver not driving), `sh_sample_o` is 1 (sample), `conv_flag_o` is 0 and `overrun_cnt_o` is 0.
- R2: A pulse on `pps_i` that is high for less than one clock period, while armed, still produces a full window and exactly one conversion start.
- R3: While armed, `gate_oe_o` is 1. It falls to 0 in the cycle after the SYNC_STAGES-th rising clock edge that follows the `pps_i` rising edge, counting the first edge after the pulse as edge 1.
- R4: `conv_start_o` is high for exactly one cycle, and that cycle begins at the (SYNC_STAGES+DELAY_STAGES)-th rising clock edge after the `pps_i` rising edge. There is one start per accepted pulse.
- R5: `sh_sample_o` is 1 during the window and the settling delay. It is 0 from the conversion start cycle for CONV_CYCLES+1 cycles, then returns to 1.
- R6: The block re-arms (`gate_oe_o` back to 1) only after `pps_i` has been seen low and the delay chain is empty. A pulse held high across the whole conversion yields one window and one start.
- R7: A rising edge of `pps_i` that arrives during a window, conversion or re-arm wait causes no window and no start, and increments `overrun_cnt_o` by one.
- R8: `overrun_cnt_o` saturates at its all-ones value (2^OVR_W-1) and does not wrap.
- R9: `conv_flag_o` goes to 1 on the cycle after a conversion start and stays set until a cycle with `ack_i` high, after which it reads 0 (a start in the same cycle wins).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz local reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pps_i | input | 1 | Raw asynchronous timing pulse (also wired to the external driver data input) |
| ack_i | input | 1 | One-cycle acknowledge that clears the conversion flag |
| gate_oe_o | output | 1 | Enable of the external three-state driver, 1 = driving |
| sh_sample_o | output | 1 | Converter sample/hold control, 1 = sample, 0 = hold |
| conv_start_o | output | 1 | One-cycle converter start pulse |
| conv_flag_o | output | 1 | Sticky flag: a conversion has been started |
| overrun_cnt_o | output | OVR_W | Saturating count of ignored pulse edges |

## Verification
On every cycle, the assertions check these relations:
- the start pulse lasts a single cycle and coincides with hold and a non-driving driver;
- the driver is never enabled in hold;
- the flag sets after each start and clears after an acknowledge;
- the overrun count moves by at most one per cycle and sticks once saturated;
- the reset state.

Only the bench scenarios can show the exact latencies of the window edge, the start and the hold interval measured from an asynchronous pulse. The same holds for a sub-cycle pulse still being caught, for a long pulse blocking re-arm, and for edges arriving mid-window or mid-conversion being counted rather than triggering.

// File: rtl/pps_conv_pkg.sv
package pps_conv_pkg;
   typedef enum logic [1:0] {
      ST_REARM = 2'd0,
      ST_ARM   = 2'd1,
      ST_WAIT  = 2'd2,
      ST_CONV  = 2'd3
   } seq_state_t;
endpackage

// File: rtl/pps_edge_capture.sv
// Edge-set capture flop: set by the pulse edge when armed, cleared from the clock domain.
module pps_edge_capture (
   input  logic pps_i,
   input  logic clr_i,
   input  logic arm_i,
   output logic cap_o
);
   always_ff @(posedge pps_i or posedge clr_i) begin
      if (clr_i)
         cap_o <= 1'b0;
      else if (arm_i)
         cap_o <= 1'b1;
   end
endmodule

// File: rtl/pps_level_sync.sv
// Plain multi-stage level synchronizer for the raw pulse level.
module pps_level_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] stg_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         stg_q <= '0;
      else
         stg_q <= {stg_q[STAGES-2:0], d_i};
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pps_shift_chain.sv
// One shift register: leading stages synchronize, trailing stages time the settle delay.
module pps_shift_chain #(
   parameter int SYNC_STAGES  = 2,
   parameter int DELAY_STAGES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cap_i,
   output logic sync_o,
   output logic trig_o,
   output logic busy_o
);
   localparam int DEPTH = SYNC_STAGES + DELAY_STAGES;

   logic [DEPTH-1:0] chain_q;
   logic             tail_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
         tail_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[DEPTH-2:0], cap_i};
         tail_q  <= chain_q[DEPTH-1];
      end
   end

   assign sync_o = chain_q[SYNC_STAGES-1];
   assign trig_o = chain_q[DEPTH-1] & ~tail_q;
   assign busy_o = |chain_q;
endmodule

// File: rtl/pps_sequencer.sv
// Window/conversion sequencing, overrun counting and the conversion flag.
module pps_sequencer
   import pps_conv_pkg::*;
#(
   parameter int CONV_CYCLES = 20,
   parameter int OVR_W       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_i,
   input  logic             trig_i,
   input  logic             chain_busy_i,
   input  logic             cap_i,
   input  logic             pps_lvl_i,
   input  logic             ack_i,
   output logic             armed_o,
   output logic             clr_o,
   output logic             gate_oe_o,
   output logic             sample_o,
   output logic             conv_start_o,
   output logic             flag_o,
   output logic [OVR_W-1:0] ovr_cnt_o
);
   localparam int CNT_W = $clog2(CONV_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);
   localparam logic [OVR_W-1:0] OVR_MAX  = '1;

   seq_state_t       state_q, state_d;
   logic [CNT_W-1:0] cnt_q;
   logic             lvl_d_q;
   logic             seen_q;
   logic             clr_q;
   logic             flag_q;
   logic [OVR_W-1:0] ovr_q;
   logic             lvl_rise;
   logic             fire;

   assign lvl_rise = pps_lvl_i & ~lvl_d_q;
   assign fire     = trig_i & (state_q == ST_WAIT);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_REARM: if (!pps_lvl_i && !chain_busy_i && !cap_i) state_d = ST_ARM;
         ST_ARM:   if (sync_i) state_d = ST_WAIT;
         ST_WAIT:  if (fire) state_d = ST_CONV;
         ST_CONV:  if (cnt_q == CNT_LAST) state_d = ST_REARM;
         default:  state_d = ST_REARM;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_REARM;
         cnt_q   <= '0;
         lvl_d_q <= 1'b0;
         seen_q  <= 1'b0;
         clr_q   <= 1'b1;
         flag_q  <= 1'b0;
         ovr_q   <= '0;
      end else begin
         state_q <= state_d;
         lvl_d_q <= pps_lvl_i;
         clr_q   <= (state_q != ST_ARM) && !pps_lvl_i;

         if (state_q == ST_CONV)
            cnt_q <= cnt_q + 1'b1;
         else
            cnt_q <= '0;

         if (state_q == ST_REARM && state_d == ST_ARM)
            seen_q <= 1'b0;
         else if (lvl_rise)
            seen_q <= 1'b1;

         if (lvl_rise && ovr_q != OVR_MAX &&
             (seen_q || state_q == ST_CONV || state_q == ST_REARM))
            ovr_q <= ovr_q + 1'b1;

         if (fire)
            flag_q <= 1'b1;
         else if (ack_i)
            flag_q <= 1'b0;
      end
   end

   assign armed_o      = (state_q == ST_ARM);
   assign clr_o        = clr_q;
   assign gate_oe_o    = (state_q == ST_ARM) & ~sync_i;
   assign sample_o     = ~(fire | (state_q == ST_CONV));
   assign conv_start_o = fire;
   assign flag_o       = flag_q;
   assign ovr_cnt_o    = ovr_q;
endmodule

// File: rtl/pps_conv_trigger.sv
module pps_conv_trigger #(
   parameter int SYNC_STAGES  = 2,
   parameter int DELAY_STAGES = 8,
   parameter int CONV_CYCLES  = 20,
   parameter int OVR_W        = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pps_i,
   input  logic             ack_i,
   output logic             gate_oe_o,
   output logic             sh_sample_o,
   output logic             conv_start_o,
   output logic             conv_flag_o,
   output logic [OVR_W-1:0] overrun_cnt_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DELAY_STAGES < 1) begin : g_bad_delay
         $error("DELAY_STAGES must be at least 1");
      end
      if (CONV_CYCLES < 1) begin : g_bad_conv
         $error("CONV_CYCLES must be at least 1");
      end
      if (OVR_W < 1) begin : g_bad_ovr
         $error("OVR_W must be at least 1");
      end
   endgenerate

   logic cap;
   logic clr;
   logic armed;
   logic sync_hi;
   logic trig;
   logic busy;
   logic pps_lvl;

   pps_edge_capture u_cap (
      .pps_i (pps_i),
      .clr_i (clr),
      .arm_i (armed),
      .cap_o (cap)
   );

   pps_shift_chain #(
      .SYNC_STAGES  (SYNC_STAGES),
      .DELAY_STAGES (DELAY_STAGES)
   ) u_chain (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_i  (cap),
      .sync_o (sync_hi),
      .trig_o (trig),
      .busy_o (busy)
   );

   pps_level_sync #(
      .STAGES (SYNC_STAGES)
   ) u_lvl (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pps_i),
      .q_o   (pps_lvl)
   );

   pps_sequencer #(
      .CONV_CYCLES (CONV_CYCLES),
      .OVR_W       (OVR_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .sync_i       (sync_hi),
      .trig_i       (trig),
      .chain_busy_i (busy),
      .cap_i        (cap),
      .pps_lvl_i    (pps_lvl),
      .ack_i        (ack_i),
      .armed_o      (armed),
      .clr_o        (clr),
      .gate_oe_o    (gate_oe_o),
      .sample_o     (sh_sample_o),
      .conv_start_o (conv_start_o),
      .flag_o       (conv_flag_o),
      .ovr_cnt_o    (overrun_cnt_o)
   );
endmodule

// File: rtl/pps_conv_trigger_chk.sv
module pps_conv_trigger_chk #(
   parameter int OVR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ack_i,
   input logic             gate_oe_o,
   input logic             sh_sample_o,
   input logic             conv_start_o,
   input logic             conv_flag_o,
   input logic [OVR_W-1:0] overrun_cnt_o
);
   localparam logic [OVR_W-1:0] OVR_MAX = '1;

   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> (!gate_oe_o && sh_sample_o && !conv_flag_o &&
                  !conv_start_o && overrun_cnt_o == '0));

   a_r4_single_start: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start_o |=> !conv_start_o);

   a_r5_hold_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start_o |-> (!sh_sample_o && !gate_oe_o));

   a_r5_sample_while_gate: assert property (@(posedge clk) disable iff (!rst_n)
      gate_oe_o |-> sh_sample_o);

   a_r9_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start_o |=> conv_flag_o);

   a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !conv_start_o) |=> !conv_flag_o);

   a_r7_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (overrun_cnt_o == $past(overrun_cnt_o) ||
                overrun_cnt_o == $past(overrun_cnt_o) + 1'b1));

   a_r8_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun_cnt_o == OVR_MAX) |=> (overrun_cnt_o == OVR_MAX));
endmodule

bind pps_conv_trigger pps_conv_trigger_chk #(.OVR_W(OVR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ack_i         (ack_i),
   .gate_oe_o     (gate_oe_o),
   .sh_sample_o   (sh_sample_o),
   .conv_start_o  (conv_start_o),
   .conv_flag_o   (conv_flag_o),
   .overrun_cnt_o (overrun_cnt_o)
);

// File: tb/pps_conv_trigger_tb.sv
module pps_conv_trigger_tb;
   localparam int CLK_PERIOD = 100;
   localparam int SYNC = 2;
   localparam int DLY  = 8;
   localparam int CONV = 20;
   localparam int OVRW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pps = 1'b0;
   logic ack = 1'b0;
   logic gate_oe, sh_sample, conv_start, conv_flag;
   logic [OVRW-1:0] ovr_cnt;

   int cyc = 0;
   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;
   int exp_q[$];

   pps_conv_trigger #(
      .SYNC_STAGES (SYNC), .DELAY_STAGES (DLY),
      .CONV_CYCLES (CONV), .OVR_W (OVRW)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .pps_i (pps), .ack_i (ack),
      .gate_oe_o (gate_oe), .sh_sample_o (sh_sample),
      .conv_start_o (conv_start), .conv_flag_o (conv_flag),
      .overrun_cnt_o (ovr_cnt)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc = cyc + 1;

   task automatic check_eq(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
      end
   endtask

   task automatic at_cyc(int t);
      do @(negedge clk); while (cyc < t);
   endtask

   // Driver: raise the pulse 30 time units after an edge and queue the expected start cycle.
   task automatic launch(int width, output int n);
      @(posedge clk);
      #30;
      n = cyc;
      exp_q.push_back(n + SYNC + DLY);
      pps = 1'b1;
      fork
         begin #(width) pps = 1'b0; end
      join_none
   endtask

   // A pulse that the block must ignore: nothing is queued.
   task automatic raw_pulse();
      @(posedge clk);
      #30 pps = 1'b1;
      #200 pps = 1'b0;
   endtask

   task automatic std_pulse(int width, bit do_ack, output int n);
      launch(width, n);
      at_cyc(n + 1);            check_eq("R3 gate on before sync", int'(gate_oe), 1);
      at_cyc(n + SYNC);         check_eq("R3 gate off after sync", int'(gate_oe), 0);
      at_cyc(n + SYNC + DLY - 1); check_eq("R5 sample during settle", int'(sh_sample), 1);
      at_cyc(n + SYNC + DLY);   check_eq("R5 hold at start", int'(sh_sample), 0);
      at_cyc(n + SYNC + DLY + 1);
      check_eq("R9 flag set", int'(conv_flag), 1);
      if (do_ack) ack = 1'b1;
      at_cyc(n + SYNC + DLY + 2);
      ack = 1'b0;
      if (do_ack) check_eq("R9 flag cleared by ack", int'(conv_flag), 0);
      at_cyc(n + SYNC + DLY + CONV);     check_eq("R5 hold last cycle", int'(sh_sample), 0);
      at_cyc(n + SYNC + DLY + CONV + 1); check_eq("R5 back to sample", int'(sh_sample), 1);
   endtask

   // Monitor: every start must match the head of the expected queue (R4).
   always @(negedge clk) begin
      if (rst_n && conv_start) begin
         if (exp_q.size() == 0) begin
            n_checks++; n_fail++;
            $display("FAIL R4 unexpected start: actual cycle %0d expected none", cyc);
         end else begin
            check_eq("R4 start cycle", cyc, exp_q.pop_front());
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int n;
      at_cyc(3);
      check_eq("R1 gate off in reset", int'(gate_oe), 0);
      check_eq("R1 sample in reset", int'(sh_sample), 1);
      check_eq("R1 flag clear in reset", int'(conv_flag), 0);
      check_eq("R1 overrun zero in reset", int'(ovr_cnt), 0);
      at_cyc(5);
      rst_n = 1'b1;
      at_cyc(10);
      check_eq("R6 armed after reset", int'(gate_oe), 1);

      // Ordinary pulse, acknowledged.
      std_pulse(1000, 1'b1, n);
      at_cyc(n + 40); check_eq("R6 re-armed", int'(gate_oe), 1);

      // Sub-cycle pulse.
      std_pulse(5, 1'b0, n);
      at_cyc(n + 40); check_eq("R2 narrow pulse re-armed", int'(gate_oe), 1);

      // Long pulse blocks re-arm until low.
      std_pulse(5000, 1'b1, n);
      at_cyc(n + 45); check_eq("R6 no re-arm while high", int'(gate_oe), 0);
      at_cyc(n + 75); check_eq("R6 re-arm after low", int'(gate_oe), 1);
      check_eq("R7 long pulse no overrun", int'(ovr_cnt), 0);

      // Edges during window and conversion are ignored and counted.
      launch(100, n);
      at_cyc(n + 5);  raw_pulse();
      at_cyc(n + 20); raw_pulse();
      at_cyc(n + 45);
      check_eq("R7 overrun count", int'(ovr_cnt), 2);
      check_eq("R7 armed after ignored edges", int'(gate_oe), 1);

      std_pulse(100, 1'b1, n);
      at_cyc(n + 40); check_eq("R7 count kept", int'(ovr_cnt), 2);

      // Saturation.
      launch(100, n);
      at_cyc(n + 5);  raw_pulse();
      at_cyc(n + 12); raw_pulse();
      at_cyc(n + 19); raw_pulse();
      at_cyc(n + 26); raw_pulse();
      at_cyc(n + 45);
      check_eq("R8 saturated count", int'(ovr_cnt), 3);

      at_cyc(n + 60);
      check_eq("R4 all starts seen", exp_q.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule